// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block is one receive-only master channel of a three-wire clocked serial link. It produces the serial clock, shifts in one frame from the serial input line, and holds the serial output line high, so the far device always sees an all-ones dummy pattern. The host sets the channel up through a configuration word and a clock-divider field, then enables the channel with a start strobe. After that, each dummy write strobe begins one frame. A frame is accepted only when the channel is idle and the clock idle-level input matches the selected polarity.

Two free-running prescalers give two operation-clock rates, and a configuration bit picks one of them for each frame. The serial clock half-period lasts (divider + 1) operation-clock ticks. A frame is 7 or 8 bits long and can be shifted in either bit order. The data can be sampled on the first or the second clock edge of each bit. The received value is right-aligned in the low byte of a readable word, and the divider sits in the bits above it. A one-cycle interrupt marks either the end of a frame or the moment the dummy data has been taken, which means the buffer is empty again.

Top module: `ssr_top`

## Requirements
- R1: After reset, `busy`, `irq` and `rd_word` are 0, while `sdo` and `sck` are 1.
- R2: A `data_we` pulse starts a frame (`busy` rises on the next edge) only if the channel has been enabled by `start_pulse`, no frame is running, and `clk_idle_lvl` equals the inverse of polarity bit [5] of the configuration word. In any other case the pulse has no effect.
- R3: Clock-select bit [0] chooses the operation clock: 0 selects prescaler PRE0_DIV and 1 selects PRE1_DIV. Each serial clock half-period lasts (divider + 1) × the selected prescale, counted in system cycles.
- R4: A frame of N bits gives exactly 2N transitions on `sck`. `sck` is back at the frame's idle level in the cycle where `busy` falls.
- R5: With phase bit [4] = 0, `sck` stays at idle when the frame is accepted, and the input is sampled on the first edge of each bit. With phase bit [4] = 1, `sck` leaves idle on acceptance, and the input is sampled on the second edge of each bit.
- R6: With order bit [2] = 0, the first received bit becomes the most significant bit of the frame.
- R7: With order bit [2] = 1, the first received bit becomes bit 0.
- R8: Length bit [3] = 1 gives 8-bit frames and 0 gives 7-bit frames. A 7-bit result is right-aligned in bits 6:0 with bit 7 reading 0, in either bit order.
- R9: With interrupt-mode bit [1] = 0, `irq` pulses for exactly one cycle, in the cycle where `busy` falls, and at no other time in the frame.
- R10: With interrupt-mode bit [1] = 1, `irq` pulses for one cycle, in the cycle where `busy` rises.
- R11: `rd_word` holds the divider in its upper DIV_W bits and the last received frame in its low 8 bits. The low byte is updated when `busy` falls.
- R12: `sdo` stays 1 at all times.
- R13: Configuration and divider writes made while `busy` is high are dropped. The running frame and later frames keep the earlier settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | Enables the channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | {polarity, phase, length, order, irq mode, clock select} |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Baud divider value |
| data_we | input | 1 | Dummy data write; starts a frame |
| clk_idle_lvl | input | 1 | Serial clock idle level setting |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out (all ones) |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt pulse |
| rd_word | output | DIV_W+8 | {divider, received byte} |

## Verification
The bench builds the block with PRE0_DIV = 1, PRE1_DIV = 3 and DIV_W = 7. These prescales keep every half-period at nine cycles or fewer, so a single run covers all 16 combinations of order, length, phase and polarity. For each combination the bench varies the clock source, the divider, the interrupt mode and the data pattern. It computes the expected frame value, the number of clock transitions and the half-period length from the settings alone. Further cases cover start gating, a frame disturbed in the middle by writes, and a larger divider.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int FRAME_W = 8;

  typedef struct packed {
    logic pol;
    logic phase;
    logic len8;
    logic lsb_first;
    logic irq_mode;
    logic clk_sel;
  } ssr_cfg_t;

  localparam int CFG_W = $bits(ssr_cfg_t);
endpackage

// File: rtl/ssr_prescale.sv
module ssr_prescale #(
  parameter int DIV0 = 2,
  parameter int DIV1 = 8
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] tick
);
  for (genvar g = 0; g < 2; g++) begin : g_pre
    localparam int D = (g == 0) ? DIV0 : DIV1;
    if (D <= 1) begin : g_pass
      assign tick[g] = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(D);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || cnt_q == CW'(D - 1)) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
      assign tick[g] = (cnt_q == CW'(D - 1));
    end
  end
endmodule

// File: rtl/ssr_baud.sv
module ssr_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             op_tick,
  input  logic [DIV_W-1:0] div,
  output logic             half_end
);
  logic [DIV_W-1:0] cnt_q;

  assign half_end = run && op_tick && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || half_end) cnt_q <= '0;
    else if (op_tick)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift
  import ssr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               sample,
  input  logic               lsb_first,
  input  logic               len8,
  input  logic               sdi,
  output logic [FRAME_W-1:0] result
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst || clear) sr_q <= '0;
    else if (sample)  sr_q <= lsb_first ? {sdi, sr_q[FRAME_W-1:1]}
                                        : {sr_q[FRAME_W-2:0], sdi};
  end

  // right-align a short frame whatever the order
  always_comb begin
    if (len8)           result = sr_q;
    else if (lsb_first) result = sr_q >> 1;
    else                result = {1'b0, sr_q[FRAME_W-2:0]};
  end
endmodule

// File: rtl/ssr_top.sv
module ssr_top
  import ssr_pkg::*;
#(
  parameter int PRE0_DIV = 2,
  parameter int PRE1_DIV = 8,
  parameter int DIV_W    = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_pulse,
  input  logic                   cfg_we,
  input  logic [CFG_W-1:0]       cfg_wdata,
  input  logic                   div_we,
  input  logic [DIV_W-1:0]       div_wdata,
  input  logic                   data_we,
  input  logic                   clk_idle_lvl,
  input  logic                   sdi,
  output logic                   sck,
  output logic                   sdo,
  output logic                   busy,
  output logic                   irq,
  output logic [DIV_W+FRAME_W-1:0] rd_word
);
  localparam int HALF_N = 2 * FRAME_W;
  localparam int HALF_W = $clog2(HALF_N);
  localparam logic [HALF_W-1:0] LAST8 = HALF_W'(HALF_N - 1);
  localparam logic [HALF_W-1:0] LAST7 = HALF_W'(HALF_N - 3);

  ssr_cfg_t           cfg_q, frm_q;
  logic [DIV_W-1:0]   div_q;
  logic               en_q, busy_q, sck_q, irq_q, idle_q, sdo_q;
  logic [HALF_W-1:0]  half_q, half_nxt, last_half;
  logic [FRAME_W-1:0] rx_q, shift_res;
  logic [1:0]         op_ticks;
  logic               op_tick, half_end, accept, sample;

  ssr_prescale #(.DIV0(PRE0_DIV), .DIV1(PRE1_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(op_ticks)
  );

  assign op_tick = op_ticks[frm_q.clk_sel];

  ssr_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy_q), .op_tick(op_tick),
    .div(div_q), .half_end(half_end)
  );

  assign accept    = data_we && en_q && !busy_q && (clk_idle_lvl == !cfg_q.pol);
  assign sample    = half_end && !half_q[0];
  assign half_nxt  = half_q + 1'b1;
  assign last_half = frm_q.len8 ? LAST8 : LAST7;

  ssr_shift u_shift (
    .clk(clk), .rst(rst), .clear(accept), .sample(sample),
    .lsb_first(frm_q.lsb_first), .len8(frm_q.len8), .sdi(sdi),
    .result(shift_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      frm_q  <= '0;
      div_q  <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      sck_q  <= 1'b1;
      irq_q  <= 1'b0;
      idle_q <= 1'b1;
      sdo_q  <= 1'b1;
      half_q <= '0;
      rx_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      sdo_q <= 1'b1;
      if (start_pulse)         en_q  <= 1'b1;
      if (cfg_we && !busy_q)   cfg_q <= ssr_cfg_t'(cfg_wdata);
      if (div_we && !busy_q)   div_q <= div_wdata;
      if (accept) begin
        frm_q  <= cfg_q;
        busy_q <= 1'b1;
        half_q <= '0;
        idle_q <= clk_idle_lvl;
        sck_q  <= clk_idle_lvl ^ cfg_q.phase;
        irq_q  <= cfg_q.irq_mode;
      end else if (busy_q) begin
        if (half_end) begin
          if (half_q == last_half) begin
            busy_q <= 1'b0;
            sck_q  <= idle_q;
            irq_q  <= !frm_q.irq_mode;
            rx_q   <= shift_res;
          end else begin
            half_q <= half_nxt;
            sck_q  <= idle_q ^ half_nxt[0] ^ frm_q.phase;
          end
        end
      end else begin
        sck_q <= clk_idle_lvl;
      end
    end
  end

  assign sck     = sck_q;
  assign sdo     = sdo_q;
  assign busy    = busy_q;
  assign irq     = irq_q;
  assign rd_word = {div_q, rx_q};
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             irq,
  input logic             sck,
  input logic             data_we,
  input logic             en_q,
  input logic             clk_idle_lvl,
  input logic             cfg_pol,
  input logic             frm_irq_mode,
  input logic             frm_len8,
  input logic             idle_q,
  input logic [DIV_W-1:0] div_q,
  input logic             rd_bit7
);
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(data_we && en_q && (clk_idle_lvl != cfg_pol))); // R2
  AST_SCK_RESTS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (sck == idle_q)); // R4
  AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !frm_len8) |-> !rd_bit7); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R9
  AST_END_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !frm_irq_mode) |-> irq); // R9
  AST_BEGIN_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && frm_irq_mode) |-> irq); // R10
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(div_q)); // R13
endmodule

bind ssr_top ssr_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .irq(irq), .sck(sck),
  .data_we(data_we), .en_q(en_q), .clk_idle_lvl(clk_idle_lvl),
  .cfg_pol(cfg_q.pol), .frm_irq_mode(frm_q.irq_mode), .frm_len8(frm_q.len8),
  .idle_q(idle_q), .div_q(div_q), .rd_bit7(rd_word[7])
);

// File: tb/test_ssr_top.sv
`timescale 1ns/1ps
module test_ssr_top;
  localparam int PRE0 = 1;
  localparam int PRE1 = 3;
  localparam int DIV_W = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start_pulse, cfg_we, div_we, data_we, clk_idle_lvl, sdi;
  logic [5:0] cfg_wdata;
  logic [DIV_W-1:0] div_wdata;
  logic sck, sdo, busy, irq;
  logic [DIV_W+7:0] rd_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ssr_top #(.PRE0_DIV(PRE0), .PRE1_DIV(PRE1), .DIV_W(DIV_W)) i_ssr_top (
    .clk(clk), .rst(rst), .start_pulse(start_pulse), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .div_we(div_we), .div_wdata(div_wdata),
    .data_we(data_we), .clk_idle_lvl(clk_idle_lvl), .sdi(sdi),
    .sck(sck), .sdo(sdo), .busy(busy), .irq(irq), .rd_word(rd_word)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic bitval(input int v, input int lsb, input int n, input int b);
    if (b >= n) return 1'b1;
    return lsb != 0 ? 1'((v >> b) & 1) : 1'((v >> (n - 1 - b)) & 1);
  endfunction

  function automatic logic [5:0] mk_cfg(input int pol, ph, len8, lsb, irqm, sel);
    return {1'(pol), 1'(ph), 1'(len8), 1'(lsb), 1'(irqm), 1'(sel)};
  endfunction

  task automatic run_frame(input int v, lsb, len8, ph, pol, sel, div, irqm,
                           input bit do_cfg, input bit disturb);
    int n, idle, samp_lvl, bi, toggles, gapbad, half, cyc, last_t, sdobad, extra;
    int mask, exp_data;
    logic prev;
    string dreq;
    n = (len8 != 0) ? 8 : 7;
    idle = (pol != 0) ? 0 : 1;
    samp_lvl = (ph != 0) ? idle : 1 - idle;
    half = (div + 1) * ((sel != 0) ? PRE1 : PRE0);
    @(negedge clk);
    if (do_cfg) begin
      cfg_we = 1'b1; cfg_wdata = mk_cfg(pol, ph, len8, lsb, irqm, sel);
      div_we = 1'b1; div_wdata = DIV_W'(div);
    end
    clk_idle_lvl = 1'(idle);
    @(negedge clk);
    cfg_we = 1'b0; div_we = 1'b0;
    bi = 0; sdi = bitval(v, lsb, n, 0); data_we = 1'b1;
    @(negedge clk);
    data_we = 1'b0;
    chk("R2", "busy after accepted write", int'(busy), 1);
    chk("R10", "irq at frame start", int'(irq), irqm);
    chk("R5", "sck level after accept", int'(sck), idle ^ ph);
    prev = 1'(idle); toggles = 0; gapbad = 0; cyc = 0; last_t = 0; sdobad = 0; extra = 0;
    while (1) begin
      if (sck !== prev) begin
        if (toggles >= 2 && cyc - last_t != half) gapbad++;
        last_t = cyc; toggles++; prev = sck;
        if (int'(sck) == samp_lvl) begin bi++; sdi = bitval(v, lsb, n, bi); end
      end
      if (sdo !== 1'b1) sdobad++;
      if (busy == 1'b0) break;
      if (cyc > 0 && irq) extra++;
      if (disturb && cyc == 5) begin
        data_we = 1'b1; cfg_we = 1'b1; cfg_wdata = mk_cfg(pol, ph, 0, lsb, irqm, sel);
        div_we = 1'b1; div_wdata = DIV_W'(div + 1);
      end
      if (disturb && cyc == 6) begin data_we = 1'b0; cfg_we = 1'b0; div_we = 1'b0; end
      if (cyc > 4000) break;
      @(negedge clk);
      cyc++;
    end
    mask = (1 << n) - 1;
    exp_data = v & mask;
    dreq = (len8 == 0) ? "R8" : ((lsb != 0) ? "R7" : "R6");
    chk("R9", "irq when busy falls", int'(irq), 1 - irqm);
    chk("R9", "stray irq inside frame", extra, 0);
    chk("R4", "sck transitions", toggles, 2 * n);
    chk("R4", "sck idle at end", int'(sck), idle);
    chk("R3", "half-period mismatches", gapbad, 0);
    chk(dreq, "received byte", int'(rd_word[7:0]), exp_data);
    chk("R11", "divider field", int'(rd_word[DIV_W+7:8]), div);
    chk("R12", "sdo low cycles", sdobad, 0);
    if (len8 == 0) chk("R8", "bit7 of short frame", int'(rd_word[7]), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pats[4];
    rst = 1'b1; start_pulse = 1'b0; cfg_we = 1'b0; div_we = 1'b0; data_we = 1'b0;
    clk_idle_lvl = 1'b1; sdi = 1'b1; cfg_wdata = '0; div_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "irq in reset", int'(irq), 0);
    chk("R1", "sdo in reset", int'(sdo), 1);
    chk("R1", "sck in reset", int'(sck), 1);
    chk("R1", "rd_word in reset", int'(rd_word), 0);
    rst = 1'b0;
    // write before the channel is enabled
    @(negedge clk); data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    chk("R2", "busy with channel disabled", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R2", "sck with channel disabled", int'(sck), 1);
    start_pulse = 1'b1;
    @(negedge clk); start_pulse = 1'b0;
    // level mismatch: polarity 0 needs level 1
    clk_idle_lvl = 1'b0;
    @(negedge clk); data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    chk("R2", "busy with level mismatch", int'(busy), 0);
    chk("R2", "sck follows idle level", int'(sck), 0);

    for (int c = 0; c < 16; c++) begin
      pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h81; pats[3] = 8'h5E ^ c;
      for (int p = 0; p < 4; p++) begin
        run_frame(pats[p], c & 1, (c >> 1) & 1, (c >> 2) & 1, (c >> 3) & 1,
                  p & 1, ((p >> 1) & 1) * 2, (c + p) & 1, 1'b1, 1'b0);
      end
    end

    // writes during a frame: R13 and R2
    run_frame(8'hC3, 0, 1, 0, 0, 0, 1, 0, 1'b1, 1'b1);
    repeat (10) begin
      @(negedge clk);
      chk("R2", "no frame from write while busy", int'(busy), 0);
    end
    chk("R13", "divider kept after busy write", int'(rd_word[DIV_W+7:8]), 1);
    run_frame(8'h6B, 0, 1, 0, 0, 0, 1, 0, 1'b0, 1'b0);

    run_frame(8'h96, 1, 1, 1, 0, 1, 5, 1, 1'b1, 1'b0);
    run_frame(8'h2D, 0, 0, 0, 1, 1, 5, 0, 1'b1, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule